// File: doc/BRIEF.md
# Serial Security Register Read Responder

This block is the target side of a four-wire serial link running in clock mode 0. It serves one read-only identification register of `NBYTES` bytes. A host pulls chip select low and shifts in a command byte on the serial input. If that byte is the read command, the host then clocks three don't-care bytes. After that, the responder shifts the register out one bit per serial clock, most significant bit first, until chip select rises.

The serial clock, chip select and serial input are sampled by a faster system clock. Each passes through a two-stage synchronizer, and edge detection follows on the serial clock. Incoming bits are taken on the rising serial-clock edge. Outgoing bits change on the falling edge. The pad driver is left outside the block. The block supplies the bit value `so` and an enable `so_oe`; with `so_oe` low the pad is in high impedance. The register image enters on a wide input port, so it can be tied to fuses or to constants.

Any other command byte silences the output for the rest of the frame. Reading past the last register byte yields a fixed filler pattern. The host treats that pattern as undefined data.

Top module: `secreg_spi_responder`

## Requirements
- R1: The command byte is taken MSB first from `si` on eight rising `sck` edges while `csn` is low. Only the value 0x77 starts a read. A bit-reversed copy (0xEE) or any other value does not.
- R2: After a read command, three further bytes (24 rising edges) are ignored. `so_oe` stays low from chip-select fall through the 32nd rising edge.
- R3: On the falling `sck` edge after the 32nd rising edge, `so_oe` goes high and `so` carries bit 7 of register byte 0. Each later falling edge presents the next lower bit. Byte k is `reg_data[8k+7:8k]`, and the bytes are sent in order k = 0, 1, 2, and so on.
- R4: Once all `NBYTES` bytes have been sent, further bytes carry the bits of `FILL_BYTE` (default 0xFF), MSB first, with `so_oe` still high.
- R5: When `csn` rises at any point, `so_oe` drops within 4 system clocks and all frame state clears. The next frame is decoded from its first bit.
- R6: After a command byte other than 0x77, `so_oe` stays low until `csn` rises, however many clocks follow.
- R7: While reset is asserted and after it is released, `so_oe` and `so` are low until a read reaches its data phase.
- R8: The byte position saturates past the end of the register. An arbitrarily long read keeps producing filler and never wraps back to byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_data | input | NBYTES*8 | Register image, byte k in bits 8k+7..8k |
| sck | input | 1 | Serial clock from host, mode 0 |
| csn | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data bit toward the pad |
| so_oe | output | 1 | Pad output enable; low means high impedance |

## Verification
A pin change reaches the edge detector two system clocks later. The output registers update one clock after that, so `so`/`so_oe` settle within four system clocks of a falling `sck` or a rising `csn`. The bench holds each `sck` level for eight system clocks. It samples `so` and `so_oe` on the falling system-clock edge just before it raises `sck`, as a mode-0 host would, so every sample falls well after the bit is due. After releasing `csn`, it waits six system clocks before checking that the output is disabled.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam logic [7:0] OPC_READ_SEC = 8'h77;
  localparam int DUMMY_BYTES = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_IGNORE = 2'd2
  } secreg_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic csn_s,
  output logic si_s
);
  logic [2:0] stg1_q, stg2_q;
  logic       sck_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q     <= 3'b010;
      stg2_q     <= 3'b010;
      sck_prev_q <= 1'b0;
    end else begin
      stg1_q     <= {sck, csn, si};
      stg2_q     <= stg1_q;
      sck_prev_q <= stg2_q[2];
    end
  end

  assign sck_rise = stg2_q[2] & ~sck_prev_q;
  assign sck_fall = ~stg2_q[2] & sck_prev_q;
  assign csn_s    = stg2_q[1];
  assign si_s     = stg2_q[0];
endmodule

// File: rtl/secreg_frame_ctl.sv
module secreg_frame_ctl
  import secreg_pkg::*;
#(
  parameter int NBYTES = 128,
  localparam int CNT_W = $clog2(DUMMY_BYTES + NBYTES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_rise,
  input  logic             csn_s,
  input  logic             si_s,
  output logic [2:0]       bit_cnt,
  output logic [CNT_W-1:0] byte_cnt,
  output secreg_state_e    state
);
  localparam logic [CNT_W-1:0] BYTE_MAX = CNT_W'(1 + DUMMY_BYTES + NBYTES);

  logic [2:0]       bit_q, bit_d;
  logic [CNT_W-1:0] byte_q, byte_d;
  logic [7:0]       opc_q, opc_d;
  logic [7:0]       opc_full;
  secreg_state_e    st_q, st_d;

  assign opc_full = {opc_q[6:0], si_s};

  always_comb begin
    bit_d  = bit_q;
    byte_d = byte_q;
    opc_d  = opc_q;
    st_d   = st_q;
    if (csn_s) begin
      bit_d  = '0;
      byte_d = '0;
      opc_d  = '0;
      st_d   = ST_IDLE;
    end else if (sck_rise) begin
      bit_d = bit_q + 3'd1;
      if (byte_q == '0) opc_d = opc_full;
      if (bit_q == 3'd7) begin
        if (byte_q != BYTE_MAX) byte_d = byte_q + 1'b1;
        if (byte_q == '0) st_d = (opc_full == OPC_READ_SEC) ? ST_READ : ST_IGNORE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      byte_q <= '0;
      opc_q  <= '0;
      st_q   <= ST_IDLE;
    end else begin
      bit_q  <= bit_d;
      byte_q <= byte_d;
      opc_q  <= opc_d;
      st_q   <= st_d;
    end
  end

  assign bit_cnt  = bit_q;
  assign byte_cnt = byte_q;
  assign state    = st_q;

  // R1: a read is entered only at the close of the command byte
  a_r1_read_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READ) && !$past(st_q == ST_READ) |-> (byte_q == 1) && (bit_q == 0));
  // R6: a rejected command stays rejected while selected
  a_r6_ignore_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGNORE) && !csn_s |=> (st_q == ST_IGNORE));
  // R8: byte position never runs past its ceiling
  a_r8_byte_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    byte_q <= BYTE_MAX);
  // R5: release clears frame position
  a_r5_clear_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (byte_q == 0) && (bit_q == 0));
endmodule

// File: rtl/secreg_tx.sv
module secreg_tx
  import secreg_pkg::*;
#(
  parameter int         NBYTES    = 128,
  parameter logic [7:0] FILL_BYTE = 8'hFF,
  localparam int CNT_W = $clog2(DUMMY_BYTES + NBYTES + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBYTES*8-1:0] reg_data,
  input  logic                sck_fall,
  input  logic                csn_s,
  input  secreg_state_e       state,
  input  logic [2:0]          bit_cnt,
  input  logic [CNT_W-1:0]    byte_cnt,
  output logic                so,
  output logic                so_oe
);
  localparam logic [CNT_W-1:0] DATA_START = CNT_W'(1 + DUMMY_BYTES);
  localparam logic [CNT_W-1:0] LIMIT      = CNT_W'(NBYTES);

  logic [CNT_W-1:0] idx, idx_c;
  logic             in_range, data_phase;
  logic [7:0]       cur_byte;
  logic             tx_bit;
  logic             so_q, so_d, oe_q, oe_d;

  always_comb begin
    data_phase = (state == ST_READ) && (byte_cnt >= DATA_START);
    idx        = byte_cnt - DATA_START;
    in_range   = idx < LIMIT;
    idx_c      = in_range ? idx : '0;
    cur_byte   = in_range ? reg_data[{idx_c, 3'b000} +: 8] : FILL_BYTE;
    tx_bit     = cur_byte[3'd7 - bit_cnt];
  end

  always_comb begin
    so_d = so_q;
    oe_d = oe_q;
    if (csn_s) begin
      so_d = 1'b0;
      oe_d = 1'b0;
    end else if (sck_fall && data_phase) begin
      so_d = tx_bit;
      oe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      so_q <= so_d;
      oe_q <= oe_d;
    end
  end

  assign so    = so_q;
  assign so_oe = oe_q;

  // R2/R6: the pad is only driven while a read is in progress
  a_r2_drive_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (state == ST_READ));
  // R3: the driver turns on only following a falling serial edge
  a_r3_enable_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> $past(sck_fall));
  // R3: the data bit holds between falling edges
  a_r3_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_fall) && !$past(csn_s) |-> $stable(so));
  // R5: releasing chip select disables the driver
  a_r5_release_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !so_oe);
endmodule

// File: rtl/secreg_spi_responder.sv
module secreg_spi_responder
  import secreg_pkg::*;
#(
  parameter int         NBYTES    = 128,
  parameter logic [7:0] FILL_BYTE = 8'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBYTES*8-1:0] reg_data,
  input  logic                sck,
  input  logic                csn,
  input  logic                si,
  output logic                so,
  output logic                so_oe
);
  localparam int CNT_W = $clog2(DUMMY_BYTES + NBYTES + 2);

  logic             sck_rise, sck_fall, csn_s, si_s;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  secreg_state_e    state;

  spi_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .si(si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .csn_s(csn_s), .si_s(si_s)
  );

  secreg_frame_ctl #(.NBYTES(NBYTES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .csn_s(csn_s), .si_s(si_s),
    .bit_cnt(bit_cnt), .byte_cnt(byte_cnt), .state(state)
  );

  secreg_tx #(.NBYTES(NBYTES), .FILL_BYTE(FILL_BYTE)) u_tx (
    .clk(clk), .rst_n(rst_n), .reg_data(reg_data), .sck_fall(sck_fall),
    .csn_s(csn_s), .state(state), .bit_cnt(bit_cnt), .byte_cnt(byte_cnt),
    .so(so), .so_oe(so_oe)
  );

  // R7: nothing is driven while chip select is inactive
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s && $past(csn_s) |-> !so_oe && !so);
endmodule

// File: tb/secreg_spi_responder_test.sv
module secreg_spi_responder_test;
  localparam int         NB   = 128;
  localparam logic [7:0] FILL = 8'hFF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NB*8-1:0] reg_data;
  logic            sck = 1'b0, csn = 1'b1, si = 1'b0;
  logic            so, so_oe;
  int              checks = 0, errors = 0;
  bit              done = 1'b0;

  always #2.5 clk = ~clk;

  secreg_spi_responder #(.NBYTES(NB), .FILL_BYTE(FILL)) uut (
    .clk(clk), .rst_n(rst_n), .reg_data(reg_data),
    .sck(sck), .csn(csn), .si(si), .so(so), .so_oe(so_oe)
  );

  function automatic logic [7:0] exp_byte(int k);
    return 8'((k * 29 + 60) ^ (k >> 3));
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int n,
                           output logic [7:0] rx, output logic [7:0] oe);
    rx = '0; oe = '0;
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i];
      repeat (8) @(negedge clk);
      rx[i] = so; oe[i] = so_oe;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame_start();
    csn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame_end(string req);
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (6) @(negedge clk);
    check(so_oe == 1'b0, req, so_oe, 0);
    repeat (4) @(negedge clk);
  endtask

  // opcode plus three dummy bytes, checking silence throughout (R2)
  task automatic send_header(input logic [7:0] opc);
    logic [7:0] rx, oe;
    xfer_bits(opc, 8, rx, oe);
    check(oe == 8'h00, "R2 opcode byte quiet", oe, 0);
    for (int d = 0; d < 3; d++) begin
      xfer_bits(8'hA5, 8, rx, oe);
      check(oe == 8'h00, "R2 dummy byte quiet", oe, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(so_oe == 1'b0 && so == 1'b0, "R7 in reset", {so_oe, so}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(so_oe == 1'b0 && so == 1'b0, "R7 after reset", {so_oe, so}, 0);
  endtask

  task automatic t_read(int n);
    logic [7:0] rx, oe, exp;
    frame_start();
    send_header(8'h77);
    for (int k = 0; k < n; k++) begin
      xfer_bits(8'h00, 8, rx, oe);
      exp = (k < NB) ? exp_byte(k) : FILL;
      check(oe == 8'hFF, "R3 driver on in data phase", oe, 8'hFF);
      if (k < NB) check(rx == exp, "R3 register byte", rx, exp);
      else        check(rx == exp, "R4 R8 filler past end", rx, exp);
    end
    frame_end("R5 release after read");
  endtask

  task automatic t_abort_data();
    logic [7:0] rx, oe;
    frame_start();
    send_header(8'h77);
    xfer_bits(8'h00, 8, rx, oe);
    check(rx == exp_byte(0), "R3 byte0 before abort", rx, exp_byte(0));
    xfer_bits(8'h00, 3, rx, oe);
    check(rx[7:5] == exp_byte(1) >> 5, "R3 partial byte1", rx[7:5], exp_byte(1) >> 5);
    frame_end("R5 release mid byte");
    t_read(2);
  endtask

  task automatic t_abort_dummy();
    logic [7:0] rx, oe;
    frame_start();
    xfer_bits(8'h77, 8, rx, oe);
    xfer_bits(8'h00, 5, rx, oe);
    check(oe == 8'h00, "R2 quiet in partial dummy", oe, 0);
    frame_end("R5 release during dummy");
    t_read(1);
  endtask

  task automatic t_bad_opcode(input logic [7:0] opc);
    logic [7:0] rx, oe;
    frame_start();
    xfer_bits(opc, 8, rx, oe);
    for (int b = 0; b < 8; b++) begin
      xfer_bits(8'h77, 8, rx, oe);
      check(oe == 8'h00, "R6 R1 other opcode silent", oe, 0);
    end
    frame_end("R6 release after other opcode");
  endtask

  initial begin
    for (int k = 0; k < NB; k++) reg_data[k*8 +: 8] = exp_byte(k);
    t_reset();
    t_read(3);
    t_bad_opcode(8'hEE);
    t_bad_opcode(8'h76);
    t_bad_opcode(8'hF7);
    t_abort_data();
    t_abort_dummy();
    t_read(NB + 3);
    t_read(1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule